// File: doc/BRIEF.md
# Replay-Capable First-Word-Fall-Through FIFO

This block is a single-clock FIFO with first-word-fall-through output. The oldest stored word is always presented on `rd_data` as soon as it is available, with `rd_valid` high. A read strobe (`rd_en` while `rd_valid`) consumes that word. No read is needed to bring a word to the output.

On top of plain queueing, the block can pin a read position and later replay from it. Raising `mark` records the position of the word currently at the head of the read side. That capture is armed only if at least `MARK_GAP` words are stored at that moment. While the armed mark is held, the writer may not reuse any location from the marked one onward, so `full` is computed against the mark instead of the read pointer.

A falling edge on the active-low `replay_n` input, sampled while `rd_en` is low, starts a rewind. The output goes not-valid and the read pointer reloads from the mark. The block then spends `SETUP_CYC` clock cycles in setup and waits for `replay_n` to return high. On the next edge the marked word falls through to the output without a read strobe. Dropping `mark` releases the write limit, and the FIFO continues as an ordinary FIFO from wherever the read side stands.

Top module: `mrk_fifo`

## Requirements
- R1: Words leave in the order they were written. A word written into an empty FIFO on clock edge k is presented with `rd_valid` high after edge k+1, with no read strobe.
- R2: `rd_en` has no effect while `rd_valid` is low. A word is consumed only on an edge where both `rd_valid` and `rd_en` are high.
- R3: With no armed mark, `full` is high exactly when `2**DEPTH_LOG2` words are stored. A write attempted while `full` is high is dropped.
- R4: A rising `mark` on an edge where at least `MARK_GAP` words are stored (the presented word included) records the location of the presented word, or of the next word if nothing is presented. While `mark` stays high, `full` rises once the number of locations from the marked one up to the write position reaches `2**DEPTH_LOG2`.
- R5: A rising `mark` with fewer than `MARK_GAP` words stored is not armed. It places no limit on writes, and a replay request made while it is held is ignored.
- R6: A replay request is an edge where `replay_n` is sampled low after being sampled high on the previous edge, with `rd_en` low and an armed mark. After that edge `rd_valid` is low. It stays low for at least `SETUP_CYC` further edges, and after that until an edge that samples `replay_n` high.
- R7: A replay request whose falling edge of `replay_n` coincides with `rd_en` high is ignored, and holding `replay_n` low afterwards does not start one.
- R8: At the first edge that ends setup with `replay_n` high, the word at the marked location is presented with `rd_valid` high and no read strobe. Later words follow in order, one per read strobe.
- R9: After `mark` is dropped, `full` is computed from the live write and read positions alone.
- R10: After reset `rd_valid` and `full` are low and the FIFO holds no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe; ignored while `full` |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free location for the writer |
| rd_en | input | 1 | Consume the presented word |
| rd_data | output | DATA_W | Presented word |
| rd_valid | output | 1 | `rd_data` holds a word |
| mark | input | 1 | Hold high to keep a replay position |
| replay_n | input | 1 | Active-low replay request |

## Verification
The hardest state to reach is a full FIFO held by an armed mark. Here the read side has moved past the mark, so the ordinary occupancy is below capacity while the writer is still blocked. A replay is then requested and must rewind across words already consumed.

The stimulus builds this state step by step. It fills part of the store, consumes a few words, raises `mark` with enough words queued, reads further, and then writes until the marked limit stops the writer. It releases `replay_n` at a known edge and counts edges until the marked word reappears. A long random phase then mixes mark pulses, replay requests with and without `rd_en`, and random traffic against a behavioural queue model.

// File: rtl/mrk_fifo_pkg.sv
package mrk_fifo_pkg;

   // Read-side sequencing for the rewind operation
   typedef enum logic [1:0] {
      RT_IDLE  = 2'd0,
      RT_SETUP = 2'd1,
      RT_HOLD  = 2'd2
   } rt_state_e;

endpackage

// File: rtl/mrk_fifo_store.sv
module mrk_fifo_store #(
   parameter int DATA_W      = 16,
   parameter int AW          = 4,
   parameter bit CLEAR_STORE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_STORE) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   // Asynchronous read; the read controller registers the result
   assign rdata = mem[raddr];

endmodule

// File: rtl/mrk_fifo_wctl.sv
module mrk_fifo_wctl #(
   parameter int AW = 4,
   parameter int PW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          mark_on,
   input  logic [PW-1:0] rd_ptr,
   input  logic [PW-1:0] mark_ptr,
   output logic [PW-1:0] wr_ptr,
   output logic          wr_fire,
   output logic          full
);

   localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

   logic [PW-1:0] base;
   logic [PW-1:0] span;

   // The oldest location the writer must protect
   assign base    = mark_on ? mark_ptr : rd_ptr;
   assign span    = wr_ptr - base;
   assign full    = (span == CAP);
   assign wr_fire = wr_en & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
      end else if (wr_fire) begin
         wr_ptr <= wr_ptr + PW'(1);
      end
   end

endmodule

// File: rtl/mrk_fifo_rctl.sv
module mrk_fifo_rctl
   import mrk_fifo_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int AW        = 4,
   parameter int PW        = AW + 1,
   parameter int MARK_GAP  = 4,
   parameter int SETUP_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              mark,
   input  logic              replay_n,
   input  logic [PW-1:0]     wr_ptr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [AW-1:0]     mem_raddr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [PW-1:0]     rd_ptr,
   output logic [PW-1:0]     mark_ptr,
   output logic              mark_on,
   output rt_state_e         rd_state
);

   localparam int CW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
   localparam logic [CW-1:0] CNT_INIT = CW'(SETUP_CYC - 1);
   localparam logic [PW-1:0] GAP_P    = PW'(MARK_GAP);

   logic          mark_q;
   logic          replay_q;
   logic [CW-1:0] setup_cnt;

   logic          pop;
   logic          rt_go;
   logic          capture;
   logic          gap_ok;
   logic          load;
   logic          avail;
   logic [PW-1:0] next_head;
   logic [PW-1:0] stored;

   assign stored    = wr_ptr - rd_ptr;
   assign gap_ok    = (stored >= GAP_P);
   assign capture   = mark & ~mark_q;
   assign pop       = rd_valid & rd_en & (rd_state == RT_IDLE);
   assign rt_go     = (rd_state == RT_IDLE) & mark_on & replay_q & ~replay_n & ~rd_en;
   assign next_head = rd_ptr + PW'(pop);
   assign avail     = (next_head != wr_ptr);
   assign load      = ((rd_state == RT_IDLE) & ~rt_go) |
                      ((rd_state == RT_HOLD) & replay_n);
   assign mem_raddr = next_head[AW-1:0];

   // Mark capture and arming
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_q   <= 1'b0;
         mark_ptr <= '0;
         mark_on  <= 1'b0;
      end else begin
         mark_q <= mark;
         if (capture) mark_ptr <= rd_ptr;
         mark_on <= mark & (capture ? gap_ok : mark_on);
      end
   end

   // Rewind sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         replay_q  <= 1'b1;
         rd_state  <= RT_IDLE;
         setup_cnt <= '0;
      end else begin
         replay_q <= replay_n;
         if (rt_go) begin
            rd_state  <= RT_SETUP;
            setup_cnt <= CNT_INIT;
         end else begin
            case (rd_state)
               RT_SETUP: begin
                  if (setup_cnt == '0) rd_state <= RT_HOLD;
                  else                 setup_cnt <= setup_cnt - CW'(1);
               end
               RT_HOLD: begin
                  if (replay_n) rd_state <= RT_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   // Read pointer and fall-through output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_ptr <= rt_go ? mark_ptr : next_head;
         if (rt_go) begin
            rd_valid <= 1'b0;
         end else if (load) begin
            rd_valid <= avail;
            if (avail) rd_data <= mem_rdata;
         end
      end
   end

endmodule

// File: rtl/mrk_fifo.sv
module mrk_fifo
   import mrk_fifo_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DEPTH_LOG2  = 4,
   parameter int MARK_GAP    = 4,
   parameter int SETUP_CYC   = 2,
   parameter bit CLEAR_STORE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              mark,
   input  logic              replay_n
);

   localparam int AW    = DEPTH_LOG2;
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   initial begin
      if (DATA_W < 1)                          $error("mrk_fifo: DATA_W must be positive");
      if (DEPTH_LOG2 < 2)                      $error("mrk_fifo: DEPTH_LOG2 must be at least 2");
      if (MARK_GAP < 1 || MARK_GAP >= DEPTH)   $error("mrk_fifo: MARK_GAP out of range");
      if (SETUP_CYC < 1)                       $error("mrk_fifo: SETUP_CYC must be at least 1");
   end

   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     rd_ptr;
   logic [PW-1:0]     mark_ptr;
   logic              mark_on;
   logic              wr_fire;
   logic [AW-1:0]     mem_raddr;
   logic [DATA_W-1:0] mem_rdata;
   rt_state_e         rd_state;

   mrk_fifo_store #(
      .DATA_W      (DATA_W),
      .AW          (AW),
      .CLEAR_STORE (CLEAR_STORE)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_fire),
      .waddr (wr_ptr[AW-1:0]),
      .wdata (wr_data),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

   mrk_fifo_wctl #(
      .AW (AW),
      .PW (PW)
   ) u_wctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .mark_on  (mark_on),
      .rd_ptr   (rd_ptr),
      .mark_ptr (mark_ptr),
      .wr_ptr   (wr_ptr),
      .wr_fire  (wr_fire),
      .full     (full)
   );

   mrk_fifo_rctl #(
      .DATA_W    (DATA_W),
      .AW        (AW),
      .PW        (PW),
      .MARK_GAP  (MARK_GAP),
      .SETUP_CYC (SETUP_CYC)
   ) u_rctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .mark      (mark),
      .replay_n  (replay_n),
      .wr_ptr    (wr_ptr),
      .mem_rdata (mem_rdata),
      .mem_raddr (mem_raddr),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .rd_ptr    (rd_ptr),
      .mark_ptr  (mark_ptr),
      .mark_on   (mark_on),
      .rd_state  (rd_state)
   );

endmodule

// File: rtl/mrk_fifo_chk.sv
module mrk_fifo_chk
   import mrk_fifo_pkg::*;
#(
   parameter int AW = 4,
   parameter int PW = AW + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic          replay_n,
   input logic          full,
   input logic          rd_valid,
   input logic [PW-1:0] wr_ptr,
   input logic [PW-1:0] rd_ptr,
   input logic [PW-1:0] mark_ptr,
   input logic          mark_on,
   input rt_state_e     rd_state
);

   localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

   logic [PW-1:0] span_mark;
   logic [PW-1:0] span_live;
   logic [PW-1:0] span_read;

   assign span_mark = wr_ptr - mark_ptr;
   assign span_live = wr_ptr - rd_ptr;
   assign span_read = rd_ptr - mark_ptr;

   AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en) |=> $stable(wr_ptr)); // R3

   AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid && !mark_on) |=> $stable(rd_ptr)); // R2

   AST_MARK_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      mark_on |-> (span_mark <= CAP && span_read <= span_mark)); // R4

   AST_SETUP_HIDES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_state != RT_IDLE) |-> !rd_valid); // R6

   AST_REPLAY_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_state == RT_IDLE && mark_on && $fell(replay_n) && !rd_en)
      |=> (rd_ptr == $past(mark_ptr) && rd_state == RT_SETUP)); // R6

   AST_REPLAY_NEEDS_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_state == RT_IDLE && rd_en && $fell(replay_n)) |=> (rd_state == RT_IDLE)); // R7

   AST_LIVE_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !mark_on |-> (span_live <= CAP)); // R9

endmodule

bind mrk_fifo mrk_fifo_chk #(
   .AW (AW),
   .PW (PW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .replay_n (replay_n),
   .full     (full),
   .rd_valid (rd_valid),
   .wr_ptr   (wr_ptr),
   .rd_ptr   (rd_ptr),
   .mark_ptr (mark_ptr),
   .mark_on  (mark_on),
   .rd_state (rd_state)
);

// File: tb/tb_mrk_fifo.sv
`timescale 1ns/1ps
module tb_mrk_fifo;

   localparam int DW    = 16;
   localparam int DL2   = 4;
   localparam int DEPTH = 1 << DL2;
   localparam int GAP   = 4;
   localparam int SETUP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic          mark = 1'b0;
   logic          replay_n = 1'b1;
   logic          full;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   mrk_fifo #(
      .DATA_W     (DW),
      .DEPTH_LOG2 (DL2),
      .MARK_GAP   (GAP),
      .SETUP_CYC  (SETUP)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .full     (full),
      .rd_en    (rd_en),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .mark     (mark),
      .replay_n (replay_n)
   );

   // Behavioural model: absolute word indices into an append-only stream
   logic [DW-1:0] stream [$];
   int  head, midx, st, cnt;
   bit  mon, mq, rq, mv;
   logic [DW-1:0] md;
   int  wseq;
   string tag_full, tag_v, tag_d;

   function automatic bit model_full();
      return (stream.size() - (mon ? midx : head)) == DEPTH;
   endfunction

   task automatic ck(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      stream.delete();
      head = 0; midx = 0; st = 0; cnt = 0;
      mon = 0; mq = 0; rq = 1; mv = 0; md = '0;
   endtask

   task automatic model_step();
      automatic bit fm  = model_full();
      automatic int wc  = stream.size();
      automatic bit pop = mv && rd_en && (st == 0);
      automatic bit rtg = (st == 0) && mon && rq && !replay_n && !rd_en;
      automatic bit cap = mark && !mq;
      automatic bit gap = (wc - head) >= GAP;
      automatic int nh  = rtg ? midx : head + int'(pop);
      automatic bit ld  = ((st == 0) && !rtg) || ((st == 2) && replay_n);
      if (rtg) begin
         st = 1; cnt = SETUP - 1; mv = 0;
      end else if (st == 1) begin
         if (cnt == 0) st = 2; else cnt--;
      end else if (st == 2 && replay_n) begin
         st = 0;
      end
      if (ld) begin
         mv = (nh < wc);
         if (mv) md = stream[nh];
      end
      if (cap) midx = head;
      mon = mark && (cap ? gap : mon);
      head = nh;
      if (wr_en && !fm) stream.push_back(wr_data);
      mq = mark;
      rq = replay_n;
   endtask

   task automatic compare();
      ck(tag_full, "full", 32'(full), 32'(model_full()));
      ck(tag_v, "rd_valid", 32'(rd_valid), 32'(mv));
      if (mv) ck(tag_d, "rd_data", 32'(rd_data), 32'(md));
   endtask

   task automatic step();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic put_word();
      wr_en = 1'b1;
      wr_data = DW'(16'h1000 + wseq);
      wseq++;
   endtask

   task automatic write_n(input int n);
      for (int i = 0; i < n; i++) begin
         put_word();
         step();
      end
      wr_en = 1'b0;
   endtask

   task automatic read_n(input int n);
      rd_en = 1'b1;
      for (int i = 0; i < n; i++) step();
      rd_en = 1'b0;
   endtask

   task automatic idle_n(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic tags(input string f, input string v, input string d);
      tag_full = f; tag_v = v; tag_d = d;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int s0;
      wseq = 0;
      model_reset();
      tags("R10", "R10", "R10");
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      ck("R10", "rd_valid after reset", 32'(rd_valid), 32'd0);
      ck("R10", "full after reset", 32'(full), 32'd0);
      compare();

      // R1: fall-through latency and ordering
      tags("R3", "R1", "R1");
      put_word();
      step();
      wr_en = 1'b0;
      ck("R1", "rd_valid one edge after write", 32'(rd_valid), 32'd0);
      step();
      ck("R1", "rd_valid two edges after write", 32'(rd_valid), 32'd1);
      ck("R1", "first word", 32'(rd_data), 32'h1000);
      read_n(1);

      // R3 / R2: fill, overfill, drain past empty
      tags("R3", "R2", "R1");
      write_n(DEPTH);
      ck("R3", "full at capacity", 32'(full), 32'd1);
      write_n(2);
      ck("R3", "full after dropped writes", 32'(full), 32'd1);
      read_n(DEPTH + 3);
      ck("R2", "rd_valid after drain", 32'(rd_valid), 32'd0);
      idle_n(2);

      // R4 / R6 / R8: marked limit and rewind
      tags("R4", "R6", "R8");
      s0 = wseq;
      write_n(8);
      idle_n(2);
      read_n(2);
      mark = 1'b1;
      step();
      read_n(3);
      write_n(12);
      ck("R4", "full at marked limit", 32'(full), 32'd1);
      replay_n = 1'b0;
      step();
      replay_n = 1'b1;
      ck("R6", "rd_valid after request", 32'(rd_valid), 32'd0);
      step();
      ck("R6", "rd_valid in setup", 32'(rd_valid), 32'd0);
      step();
      ck("R6", "rd_valid end of setup", 32'(rd_valid), 32'd0);
      step();
      ck("R8", "rd_valid after setup", 32'(rd_valid), 32'd1);
      ck("R8", "replayed word", 32'(rd_data), 32'(16'h1000 + s0 + 2));
      read_n(1);
      ck("R8", "word after replayed", 32'(rd_data), 32'(16'h1000 + s0 + 3));

      // R6: hold replay_n low past setup
      replay_n = 1'b0;
      step();
      idle_n(4);
      ck("R6", "rd_valid while request held", 32'(rd_valid), 32'd0);
      replay_n = 1'b1;
      step();
      ck("R8", "second replay word", 32'(rd_data), 32'(16'h1000 + s0 + 2));
      read_n(2);

      // R7: request coinciding with a read strobe is ignored
      tags("R4", "R7", "R7");
      rd_en = 1'b1;
      replay_n = 1'b0;
      step();
      rd_en = 1'b0;
      step();
      replay_n = 1'b1;
      step();
      ck("R7", "rd_valid after rejected request", 32'(rd_valid), 32'd1);
      ck("R7", "data after rejected request", 32'(rd_data), 32'(16'h1000 + s0 + 5));

      // R9: releasing the mark
      tags("R9", "R9", "R9");
      mark = 1'b0;
      step();
      ck("R9", "full after mark drop", 32'(full), 32'd0);
      write_n(5);
      ck("R9", "full from live pointers", 32'(full), 32'd1);
      read_n(DEPTH + 2);

      // R5: mark with too little data is not armed
      tags("R5", "R5", "R5");
      write_n(2);
      idle_n(2);
      mark = 1'b1;
      step();
      read_n(2);
      write_n(DEPTH - 1);
      ck("R5", "full with unarmed mark", 32'(full), 32'd0);
      replay_n = 1'b0;
      step();
      replay_n = 1'b1;
      ck("R5", "rd_valid after ignored request", 32'(rd_valid), 32'd1);
      step();
      mark = 1'b0;
      read_n(DEPTH + 2);

      // Random traffic against the model
      tags("R3", "R2", "R1");
      for (int i = 0; i < 4000; i++) begin
         wr_en = ($urandom_range(0, 99) < 55);
         wr_data = DW'($urandom);
         rd_en = ($urandom_range(0, 99) < 45);
         if ($urandom_range(0, 99) < 3) mark = ~mark;
         replay_n = ($urandom_range(0, 99) < 6) ? 1'b0 : 1'b1;
         step();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule